// File: doc/BRIEF.md
# Lazy Condition-Code Evaluator

This block keeps a processor's condition codes in deferred form. It does not compute flags when an arithmetic or logical operation completes. It stores a short record instead: an operation tag, an operand size, an extend bit and two data values. The flags are worked out from that record only when something asks for them. This takes the flag logic out of the ALU's critical path. The cost is paid on the rarer occasions when the flags are actually read.

An ALU posts a record after every flag-setting operation. Software-visible moves to the flag register use the direct flag-write port. A read request returns the 5-bit flag word one cycle later. A flush request also returns the flag word, and at the same time rewrites the stored record into explicit form. Later reads are then answered without reconstruction. Records with an unknown tag or an unsupported size raise an error output on read or flush.

Top module: `lcc_top`

## Requirements
- R1: After reset, `flags_o`, `flags_vld_o` and `err_o` are 0. The stored state is explicit with every flag clear, so the first read returns 5'b00000.
- R2: The flag word packs X, N, Z, V, C in bits 4, 3, 2, 1, 0. A read or flush issued in cycle k sets `flags_vld_o` in cycle k+1, with the flags of the state held at the start of cycle k. In cycles with neither request, `flags_vld_o` is 0.
- R3: A direct flag write stores the flags in explicit form (tag 0): N and V as all-ones or zero, Z inverted. A later read returns exactly the written word.
- R4: Add record (tag 1): `rec_a` is the result, `rec_b` the second operand, and `rec_x` the carry. The first operand is rebuilt as the result minus the second operand, sign-extended to the size. V is bit 31 of (res^src1)&~(src1^src2). C and X equal the stored extend bit. N and Z come from the result.
- R5: Subtract record (tag 2): the first operand is rebuilt as the result plus the second operand, sign-extended to the size. V is bit 31 of (res^src1)&(src1^src2). C and X equal the stored extend bit. N and Z come from the result.
- R6: Compare record (tag 3): `rec_a` and `rec_b` are the two operands. The result is their difference, sign-extended to the size, and gives N, Z and V. C is the unsigned less-than of `rec_a` against `rec_b`. X is `rec_x`.
- R7: Logical record (tag 4): C and V read as 0. N and Z come from `rec_a`, `rec_b` is ignored, and X is `rec_x`.
- R8: The size code selects the sign extension used in reconstruction: 0 for byte (bit 7), 1 for word (bit 15), 2 for long.
- R9: A flush returns the evaluated flags and, in the same cycle, replaces the stored record with those flags in explicit form. A following read returns the same word.
- R10: A tag of 5 to 7, or size code 3 with tag 1 to 3, makes a read or flush respond with `err_o`=1 and flags 0. A flush in that case leaves the stored state unchanged.
- R11: Within one cycle, a record has priority over a flag write, and a flag write has priority over the flush's rewrite.

Each check below names the requirement it verifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Post an operation record this cycle |
| rec_tag | input | 3 | Operation tag (0 explicit, 1 add, 2 sub, 3 cmp, 4 logic) |
| rec_size | input | 2 | Operand size (0 byte, 1 word, 2 long) |
| rec_x | input | 1 | Extend / carry bit of the operation |
| rec_a | input | DW | Result (add, sub, logic) or first operand (cmp) |
| rec_b | input | DW | Second operand |
| flag_we | input | 1 | Direct flag write |
| flag_in | input | 5 | Flag word to write {X,N,Z,V,C} |
| flush | input | 1 | Evaluate, respond and store explicitly |
| rd_req | input | 1 | Read request |
| flags_o | output | 5 | Evaluated flag word {X,N,Z,V,C} |
| flags_vld_o | output | 1 | Response valid |
| err_o | output | 1 | Response refers to an unknown tag or size |

## Verification
The checks take for granted that byte and word records arrive with their data values already sign-extended to 32 bits, as an ALU hands them over. They also assume that an add or subtract record carries the carry-out or borrow of the real operation in `rec_x`. The stimulus builds every record from a pair of source operands: it computes the sized result, the carry and the sign-extended values in the bench, and posts only those. The compare carry check sees unsigned order on the extended operands, which matches sized unsigned order under that assumption.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
    localparam int FLAG_W = 5;
    localparam int FX = 4;
    localparam int FN = 3;
    localparam int FZ = 2;
    localparam int FV = 1;
    localparam int FC = 0;

    localparam logic [2:0] TAG_FLAGS = 3'd0;
    localparam logic [2:0] TAG_ADD   = 3'd1;
    localparam logic [2:0] TAG_SUB   = 3'd2;
    localparam logic [2:0] TAG_CMP   = 3'd3;
    localparam logic [2:0] TAG_LOGIC = 3'd4;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_LONG = 2'd2;
endpackage

// File: rtl/lcc_explicit.sv
module lcc_explicit
    import lcc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [FLAG_W-1:0] flags_i,
    output logic              x_o,
    output logic              c_o,
    output logic [DW-1:0]     n_o,
    output logic [DW-1:0]     z_o,
    output logic [DW-1:0]     v_o
);
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    always_comb begin
        x_o = flags_i[FX];
        c_o = flags_i[FC];
        n_o = flags_i[FN] ? '1 : '0;
        // zero in the slot means the Z flag is set
        z_o = flags_i[FZ] ? '0 : ONE;
        v_o = flags_i[FV] ? '1 : '0;
    end
endmodule

// File: rtl/lcc_eval.sv
module lcc_eval
    import lcc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [2:0]        tag_i,
    input  logic [1:0]        size_i,
    input  logic              x_i,
    input  logic              c_i,
    input  logic [DW-1:0]     n_i,
    input  logic [DW-1:0]     z_i,
    input  logic [DW-1:0]     v_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              bad_o
);
    function automatic logic [DW-1:0] sext(input logic [DW-1:0] val, input logic [1:0] sz);
        case (sz)
            SZ_BYTE: sext = {{(DW-8){val[7]}}, val[7:0]};
            SZ_WORD: sext = {{(DW-16){val[15]}}, val[15:0]};
            default: sext = val;
        endcase
    endfunction

    logic [DW-1:0] src1, src2, res, nv, zv, vv;
    logic          cb;

    always_comb begin
        src1  = '0;
        src2  = '0;
        res   = '0;
        nv    = n_i;
        zv    = z_i;
        vv    = v_i;
        cb    = c_i;
        bad_o = 1'b0;
        case (tag_i)
            TAG_FLAGS: ;
            TAG_ADD: begin
                bad_o = (size_i == 2'd3);
                res   = n_i;
                src2  = v_i;
                src1  = sext(res - src2, size_i);
                nv    = res;
                zv    = res;
                vv    = (res ^ src1) & ~(src1 ^ src2);
                cb    = x_i;
            end
            TAG_SUB: begin
                bad_o = (size_i == 2'd3);
                res   = n_i;
                src2  = v_i;
                src1  = sext(res + src2, size_i);
                nv    = res;
                zv    = res;
                vv    = (res ^ src1) & (src1 ^ src2);
                cb    = x_i;
            end
            TAG_CMP: begin
                bad_o = (size_i == 2'd3);
                src1  = n_i;
                src2  = v_i;
                res   = sext(src1 - src2, size_i);
                nv    = res;
                zv    = res;
                vv    = (res ^ src1) & (src1 ^ src2);
                cb    = (src1 < src2);
            end
            TAG_LOGIC: begin
                zv = n_i;
                vv = '0;
                cb = 1'b0;
            end
            default: bad_o = 1'b1;
        endcase
        if (bad_o) begin
            flags_o = '0;
        end else begin
            flags_o = {x_i, nv[DW-1], (zv == '0), vv[DW-1], cb};
        end
    end
endmodule

// File: rtl/lcc_top.sv
module lcc_top
    import lcc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    input  logic [2:0]        rec_tag,
    input  logic [1:0]        rec_size,
    input  logic              rec_x,
    input  logic [DW-1:0]     rec_a,
    input  logic [DW-1:0]     rec_b,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_in,
    input  logic              flush,
    input  logic              rd_req,
    output logic [FLAG_W-1:0] flags_o,
    output logic              flags_vld_o,
    output logic              err_o
);
    localparam int NCVT = 2;  // 0: direct write, 1: flush rewrite

    typedef struct packed {
        logic [2:0]        tag;
        logic [1:0]        size;
        logic              x;
        logic              c;
        logic [DW-1:0]     n;
        logic [DW-1:0]     z;
        logic [DW-1:0]     v;
        logic [FLAG_W-1:0] flags;
        logic              vld;
        logic              err;
    } state_t;

    state_t st_d, st_q;

    logic [FLAG_W-1:0] ev_flags;
    logic              ev_bad;

    lcc_eval #(.DW(DW)) eval_i (
        .tag_i   (st_q.tag),
        .size_i  (st_q.size),
        .x_i     (st_q.x),
        .c_i     (st_q.c),
        .n_i     (st_q.n),
        .z_i     (st_q.z),
        .v_i     (st_q.v),
        .flags_o (ev_flags),
        .bad_o   (ev_bad)
    );

    logic [FLAG_W-1:0] cv_in [NCVT];
    logic              cv_x  [NCVT];
    logic              cv_c  [NCVT];
    logic [DW-1:0]     cv_n  [NCVT];
    logic [DW-1:0]     cv_z  [NCVT];
    logic [DW-1:0]     cv_v  [NCVT];

    assign cv_in[0] = flag_in;
    assign cv_in[1] = ev_flags;

    for (genvar g = 0; g < NCVT; g++) begin : g_cvt
        lcc_explicit #(.DW(DW)) cvt_i (
            .flags_i (cv_in[g]),
            .x_o     (cv_x[g]),
            .c_o     (cv_c[g]),
            .n_o     (cv_n[g]),
            .z_o     (cv_z[g]),
            .v_o     (cv_v[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = rd_req | flush;
        if (rd_req || flush) begin
            st_d.flags = ev_flags;
            st_d.err   = ev_bad;
        end
        if (rec_valid) begin
            st_d.tag  = rec_tag;
            st_d.size = rec_size;
            st_d.x    = rec_x;
            st_d.c    = rec_x;
            st_d.n    = rec_a;
            st_d.z    = rec_a;
            st_d.v    = rec_b;
        end else if (flag_we) begin
            st_d.tag  = TAG_FLAGS;
            st_d.size = SZ_LONG;
            st_d.x    = cv_x[0];
            st_d.c    = cv_c[0];
            st_d.n    = cv_n[0];
            st_d.z    = cv_z[0];
            st_d.v    = cv_v[0];
        end else if (flush && !ev_bad) begin
            st_d.tag  = TAG_FLAGS;
            st_d.size = SZ_LONG;
            st_d.x    = cv_x[1];
            st_d.c    = cv_c[1];
            st_d.n    = cv_n[1];
            st_d.z    = cv_z[1];
            st_d.v    = cv_v[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.tag  <= TAG_FLAGS;
            st_q.size <= SZ_LONG;
            st_q.z    <= {{(DW-1){1'b0}}, 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o     = st_q.flags;
    assign flags_vld_o = st_q.vld;
    assign err_o       = st_q.err;
endmodule

// File: rtl/lcc_chk.sv
module lcc_chk
    import lcc_pkg::*;
#(
    parameter int DW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rec_valid,
    input logic [2:0]        rec_tag,
    input logic [1:0]        rec_size,
    input logic              rec_x,
    input logic [DW-1:0]     rec_a,
    input logic [DW-1:0]     rec_b,
    input logic              flag_we,
    input logic [FLAG_W-1:0] flag_in,
    input logic              flush,
    input logic              rd_req,
    input logic [FLAG_W-1:0] flags_o,
    input logic              flags_vld_o,
    input logic              err_o
);
    // R2
    rd_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> flags_vld_o);

    // R2
    idle_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && !flush) |=> !flags_vld_o);

    // R3
    flag_rt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !rec_valid) ##1 (rd_req && !rec_valid && !flag_we)
        |=> (flags_o == $past(flag_in, 2)) && !err_o);

    // R6
    cmp_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_tag == TAG_CMP && rec_size == SZ_LONG)
        ##1 (rd_req && !rec_valid && !flag_we && !flush)
        |=> flags_o[FC] == ($past(rec_a, 2) < $past(rec_b, 2)));

    // R7
    logic_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_tag == TAG_LOGIC)
        ##1 (rd_req && !rec_valid && !flag_we && !flush)
        |=> flags_o[FV] == 1'b0 && flags_o[FC] == 1'b0 && !err_o);

    // R10
    bad_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_tag > TAG_LOGIC)
        ##1 (rd_req && !rec_valid && !flag_we)
        |=> err_o && flags_o == '0);

    // R9
    flush_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !rec_valid && !flag_we)
        ##1 (rd_req && !rec_valid && !flag_we && !flush)
        |=> $stable(flags_o) && $stable(err_o));
endmodule

bind lcc_top lcc_chk #(.DW(DW)) chk_i (.*);

// File: tb/lcc_top_tb_top.sv
module lcc_top_tb_top;
    import lcc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rec_valid;
    logic [2:0]  rec_tag;
    logic [1:0]  rec_size;
    logic        rec_x;
    logic [31:0] rec_a, rec_b;
    logic        flag_we;
    logic [4:0]  flag_in;
    logic        flush, rd_req;
    logic [4:0]  flags_o;
    logic        flags_vld_o, err_o;

    always #10 clk = ~clk;

    lcc_top #(.DW(32)) dut_i (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [4:0] qf[$];
    logic       qe[$];
    string      qn[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nb(input logic [1:0] sz);
        return (sz == 2'd0) ? 8 : ((sz == 2'd1) ? 16 : 32);
    endfunction

    function automatic logic [31:0] msk(input logic [1:0] sz);
        return (nb(sz) == 32) ? 32'hffff_ffff : ((32'h1 << nb(sz)) - 32'h1);
    endfunction

    function automatic logic [31:0] sx(input logic [31:0] v, input logic [1:0] sz);
        logic [31:0] m;
        m = msk(sz);
        return v[nb(sz)-1] ? (v | ~m) : (v & m);
    endfunction

    function automatic logic sg(input logic [31:0] v, input logic [1:0] sz);
        return v[nb(sz)-1];
    endfunction

    // expected flags of a+b / a-b at size sz, plus the record the ALU would post
    task automatic ref_arith(input bit is_sub, input logic [31:0] a, input logic [31:0] b,
                             input logic [1:0] sz, output logic [31:0] r_ext,
                             output logic cy, output logic [4:0] f);
        logic [32:0] s;
        logic [31:0] r;
        logic        ov;
        if (is_sub) begin
            s  = {1'b0, a & msk(sz)} - {1'b0, b & msk(sz)};
            cy = s[32];
        end else begin
            s  = {1'b0, a & msk(sz)} + {1'b0, b & msk(sz)};
            cy = s[nb(sz)];
        end
        r = s[31:0] & msk(sz);
        if (is_sub) ov = (sg(a, sz) != sg(b, sz)) && (sg(r, sz) != sg(a, sz));
        else        ov = (sg(a, sz) == sg(b, sz)) && (sg(r, sz) != sg(a, sz));
        f     = {cy, sg(r, sz), (r == 32'h0), ov, cy};
        r_ext = sx(r, sz);
    endtask

    function automatic logic [4:0] ref_cmp(input logic xin, input logic [31:0] a,
                                           input logic [31:0] b, input logic [1:0] sz);
        logic [31:0] d;
        logic        ov;
        d  = (a - b) & msk(sz);
        ov = (sg(a, sz) != sg(b, sz)) && (sg(d, sz) != sg(a, sz));
        return {xin, sg(d, sz), (d == 32'h0), ov, ((a & msk(sz)) < (b & msk(sz)))};
    endfunction

    task automatic push_exp(input logic [4:0] f, input logic e, input string nm);
        qf.push_back(f);
        qe.push_back(e);
        qn.push_back(nm);
    endtask

    task automatic cycle_end();
        @(negedge clk);
        rec_valid = 1'b0;
        flag_we   = 1'b0;
        flush     = 1'b0;
        rd_req    = 1'b0;
    endtask

    task automatic set_rec(input logic [2:0] t, input logic [1:0] sz, input logic x,
                           input logic [31:0] a, input logic [31:0] b);
        rec_valid = 1'b1;
        rec_tag   = t;
        rec_size  = sz;
        rec_x     = x;
        rec_a     = a;
        rec_b     = b;
    endtask

    task automatic do_rec(input logic [2:0] t, input logic [1:0] sz, input logic x,
                          input logic [31:0] a, input logic [31:0] b);
        set_rec(t, sz, x, a, b);
        cycle_end();
    endtask

    task automatic do_read(input logic [4:0] f, input logic e, input string nm);
        rd_req = 1'b1;
        push_exp(f, e, nm);
        cycle_end();
    endtask

    task automatic do_arith(input bit is_sub, input logic [31:0] a, input logic [31:0] b,
                            input logic [1:0] sz, input string nm);
        logic [31:0] r;
        logic        cy;
        logic [4:0]  f;
        ref_arith(is_sub, a, b, sz, r, cy, f);
        do_rec(is_sub ? TAG_SUB : TAG_ADD, sz, cy, r, sx(b, sz));
        do_read(f, 1'b0, nm);
    endtask

    task automatic do_cmp(input logic x, input logic [31:0] a, input logic [31:0] b,
                          input logic [1:0] sz, input string nm);
        do_rec(TAG_CMP, sz, x, sx(a, sz), sx(b, sz));
        do_read(ref_cmp(x, a, b, sz), 1'b0, nm);
    endtask

    // scoreboard monitor: sample halfway between an edge and the next falling edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n && flags_vld_o) begin
                if (qf.size() == 0) begin
                    chk(1'b0, "R2 unexpected response", {26'h0, err_o, flags_o}, 32'h0);
                end else begin
                    logic [4:0] ef;
                    logic       ee;
                    string      nm;
                    ef = qf.pop_front();
                    ee = qe.pop_front();
                    nm = qn.pop_front();
                    chk(flags_o == ef && err_o == ee, nm,
                        {26'h0, err_o, flags_o}, {26'h0, ee, ef});
                end
            end
        end
    end

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", qf.size(), 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        rec_valid = 1'b0; rec_tag = '0; rec_size = '0; rec_x = 1'b0;
        rec_a = '0; rec_b = '0; flag_we = 1'b0; flag_in = '0;
        flush = 1'b0; rd_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(flags_o == 5'b0 && !flags_vld_o && !err_o, "R1 reset outputs",
            {25'h0, flags_vld_o, err_o, flags_o}, 32'h0);
        do_read(5'b00000, 1'b0, "R1 first read");

        // R3 direct writes, R2 bit packing
        flag_we = 1'b1; flag_in = 5'b10110; cycle_end();
        do_read(5'b10110, 1'b0, "R3 R2 write 10110");
        flag_we = 1'b1; flag_in = 5'b01001; cycle_end();
        do_read(5'b01001, 1'b0, "R3 R2 write 01001");

        // R4 add
        do_arith(1'b0, 32'h7fff_ffff, 32'h0000_0001, SZ_LONG, "R4 add long overflow");
        do_arith(1'b0, 32'hffff_ffff, 32'h0000_0001, SZ_LONG, "R4 add long carry zero");
        do_arith(1'b0, 32'h0000_1234, 32'h0000_0100, SZ_LONG, "R4 add long plain");
        // R8 size-dependent extension
        do_arith(1'b0, 32'h0000_7fff, 32'h0000_0001, SZ_WORD, "R8 R4 add word overflow");
        do_arith(1'b0, 32'h0000_00ff, 32'h0000_0001, SZ_BYTE, "R8 R4 add byte carry");

        // R5 subtract
        do_arith(1'b1, 32'h0000_0080, 32'h0000_0001, SZ_BYTE, "R8 R5 sub byte overflow");
        do_arith(1'b1, 32'h0000_0000, 32'h0000_0001, SZ_LONG, "R5 sub long borrow");
        do_arith(1'b1, 32'h8000_0000, 32'h0000_0001, SZ_LONG, "R5 sub long overflow");
        do_arith(1'b1, 32'h0000_5000, 32'h0000_5000, SZ_WORD, "R8 R5 sub word zero");

        // R6 compare
        do_cmp(1'b0, 32'h0000_0005, 32'h0000_0010, SZ_LONG, "R6 cmp long below");
        do_cmp(1'b1, 32'h0000_0080, 32'h0000_0001, SZ_BYTE, "R8 R6 cmp byte overflow");
        do_cmp(1'b0, 32'h0000_1234, 32'h0000_1234, SZ_WORD, "R6 cmp word equal");
        do_cmp(1'b0, 32'h8000_0000, 32'h7fff_ffff, SZ_LONG, "R6 cmp long signed ovf");

        // R7 logical: second value ignored
        do_rec(TAG_LOGIC, SZ_LONG, 1'b1, 32'h0, 32'hffff_ffff);
        do_read(5'b10100, 1'b0, "R7 logic zero");
        do_rec(TAG_LOGIC, SZ_LONG, 1'b0, 32'h8000_0000, 32'hffff_ffff);
        do_read(5'b01000, 1'b0, "R7 logic negative");

        // R9 flush then read
        do_arith(1'b0, 32'h7fff_ffff, 32'h1, SZ_LONG, "R4 add before flush");
        flush = 1'b1; push_exp(5'b01010, 1'b0, "R9 flush response"); cycle_end();
        do_read(5'b01010, 1'b0, "R9 read after flush");

        // R10 unknown tag and size
        do_rec(3'd6, SZ_LONG, 1'b1, 32'h1, 32'h2);
        do_read(5'b00000, 1'b1, "R10 unknown tag read");
        flush = 1'b1; push_exp(5'b00000, 1'b1, "R10 unknown tag flush"); cycle_end();
        do_read(5'b00000, 1'b1, "R10 state kept after bad flush");
        do_rec(TAG_ADD, 2'd3, 1'b0, 32'h1, 32'h1);
        do_read(5'b00000, 1'b1, "R10 bad size");

        // R11 priorities
        set_rec(TAG_LOGIC, SZ_LONG, 1'b0, 32'h0, 32'h0);
        flag_we = 1'b1; flag_in = 5'b11111; cycle_end();
        do_read(5'b00100, 1'b0, "R11 record beats flag write");
        flag_we = 1'b1; flag_in = 5'b10001; rd_req = 1'b1;
        push_exp(5'b00100, 1'b0, "R11 read sees old state"); cycle_end();
        do_read(5'b10001, 1'b0, "R11 write after same-cycle read");
        flag_we = 1'b1; flag_in = 5'b00011; flush = 1'b1;
        push_exp(5'b10001, 1'b0, "R11 flush with write"); cycle_end();
        do_read(5'b00011, 1'b0, "R11 write beats flush rewrite");

        repeat (3) @(negedge clk);
        chk(qf.size() == 0, "R2 all responses seen", qf.size(), 32'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule